// File: doc/BRIEF.md
# Fully-Associative Address Translation Buffer

This block holds a small set of recently used page mappings. Each mapping turns a virtual page number into a physical frame number. Every slot stores the page number, an address-space tag, the frame number, read and write permission bits, and two bits for the page-replacement software: a used bit and a dirty bit. A lookup presents a page number, the current address-space tag and the access kind (read or write). All slots are compared in parallel. The answer comes back in the same cycle as a hit with the frame number, a miss, or a protection fault. The page offset passes by untranslated, because virtual and physical pages have the same size.

A refill writes one new mapping. It goes into the lowest-numbered empty slot. When no slot is empty, it goes into the slot named by a 4-bit pseudo-random shift register. Two kinds of invalidation are available: one clears every slot, the other clears only the slots that carry a given address-space tag. Both act in a single cycle. Software that walks the page tables on a miss or a fault is outside this block.

The response logic is a combinational classifier with four named outcomes. RSP_NONE means no lookup is active. RSP_MISS means a lookup matched no slot. RSP_HIT means one slot matched and the access is permitted. RSP_FAULT means one slot matched but the access is not permitted. Each cycle the outcome is chosen from lookup-valid, any-match and permission, in that order, and a unique case decodes it onto the result pins.

Top module: `tlb_fa`

## Requirements
- R1: After reset, every slot is empty and every lookup reports a miss.
- R2: A lookup whose page number and address-space tag both equal those of a valid slot, with the access permitted, raises lk_hit in the same cycle and drives that slot's frame number on lk_pfn. lk_pfn is zero when there is no hit.
- R3: A slot whose tag differs from the lookup tag never matches. Slots with the same page number and different tags coexist, and each returns its own frame number.
- R4: When lk_valid is high, exactly one of lk_hit, lk_miss and lk_fault is high. When lk_valid is low, all three are low. A read (lk_write=0) to a slot with fill_rd=0 faults. A write (lk_write=1) to a slot with fill_wr=0 faults.
- R5: On a hit or a fault, lk_used shows the slot's stored used bit. The bit is set at the clock edge of any matching lookup, including a faulting one. A refill clears it.
- R6: On a hit or a fault, lk_dirty shows the slot's stored dirty bit. The bit is set only by a permitted write lookup. A refill clears it.
- R7: A refill goes into the lowest-indexed empty slot when one exists, so no valid mapping is displaced.
- R8: With no empty slot, a refill replaces the slot whose index equals a 4-bit shift register. The register is seeded to 1 at reset and moves on each accepted refill by next = {q[2:0], q[3]^q[2]}.
- R9: flush_all empties every slot at the next clock edge.
- R10: flush_by_asid empties exactly the slots whose tag equals flush_asid and leaves all others hitting.
- R11: A refill in the same cycle as either flush is dropped, and the shift register does not move.
- R12: At most one slot matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Access kind: 1 write, 0 read |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_asid | input | 8 | Current address-space tag |
| lk_hit | output | 1 | Permitted match |
| lk_miss | output | 1 | No matching slot |
| lk_fault | output | 1 | Match but access not permitted |
| lk_pfn | output | 20 | Frame number of the hitting slot |
| lk_used | output | 1 | Stored used bit of the matching slot |
| lk_dirty | output | 1 | Stored dirty bit of the matching slot |
| fill_valid | input | 1 | Refill request |
| fill_vpn | input | 20 | Page number of the new mapping |
| fill_asid | input | 8 | Tag of the new mapping |
| fill_pfn | input | 20 | Frame number of the new mapping |
| fill_rd | input | 1 | Read permitted |
| fill_wr | input | 1 | Write permitted |
| flush_all | input | 1 | Empty every slot |
| flush_by_asid | input | 1 | Empty slots with a matching tag |
| flush_asid | input | 8 | Tag for selective flush |

## Verification
The single-match property relies on the input never refilling a page number and tag pair that is already resident. The bench keeps to this by giving every refill a pair its reference model shows to be absent. The used-bit property holds only when no refill or flush falls between two identical lookups. The bench never overlaps lookups with refills or flushes, so the dropped-refill case of R11 is driven only against flushes. The reference model tracks the shift register, the slot contents and the empty-slot preference arithmetically, and it sweeps every resident mapping after each phase.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        RSP_NONE  = 2'd0,
        RSP_HIT   = 2'd1,
        RSP_MISS  = 2'd2,
        RSP_FAULT = 2'd3
    } resp_t;

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
    parameter int W = 4,
    parameter logic [W-1:0] TAPS = 4'b1100,
    parameter logic [W-1:0] SEED = 4'b0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] q
);
    logic fb;

    assign fb = ^(q & TAPS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= SEED;
        end else if (step) begin
            q <= {q[W-2:0], fb};
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  valid_vec,
    input  logic [IW-1:0] rand_idx,
    output logic [IW-1:0] idx
);
    always_comb begin
        idx = rand_idx;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_slot.sv
module tlb_slot #(
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              clr_tag,
    input  logic [ASID_W-1:0] clr_asid,
    input  logic              load,
    input  logic [VPN_W-1:0]  ld_vpn,
    input  logic [ASID_W-1:0] ld_asid,
    input  logic [PFN_W-1:0]  ld_pfn,
    input  logic              ld_rd,
    input  logic              ld_wr,
    input  logic              probe,
    input  logic              probe_write,
    input  logic [VPN_W-1:0]  probe_vpn,
    input  logic [ASID_W-1:0] probe_asid,
    output logic              valid,
    output logic              match,
    output logic [PFN_W-1:0]  pfn,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              used,
    output logic              dirty
);
    logic [VPN_W-1:0]  vpn_q;
    logic [ASID_W-1:0] asid_q;

    assign match = valid && (vpn_q == probe_vpn) && (asid_q == probe_asid);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            used   <= 1'b0;
            dirty  <= 1'b0;
            vpn_q  <= '0;
            asid_q <= '0;
            pfn    <= '0;
            rd_ok  <= 1'b0;
            wr_ok  <= 1'b0;
        end else if (clr_all) begin
            valid <= 1'b0;
        end else if (clr_tag && (asid_q == clr_asid)) begin
            valid <= 1'b0;
        end else if (load) begin
            valid  <= 1'b1;
            used   <= 1'b0;
            dirty  <= 1'b0;
            vpn_q  <= ld_vpn;
            asid_q <= ld_asid;
            pfn    <= ld_pfn;
            rd_ok  <= ld_rd;
            wr_ok  <= ld_wr;
        end else if (probe && match) begin
            used <= 1'b1;
            if (probe_write && wr_ok) begin
                dirty <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int N      = 16,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic              lk_write,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic              lk_used,
    output logic              lk_dirty,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_rd,
    input  logic              fill_wr,
    input  logic              flush_all,
    input  logic              flush_by_asid,
    input  logic [ASID_W-1:0] flush_asid
);
    localparam int IW = $clog2(N);

    logic [N-1:0]            valid_vec;
    logic [N-1:0]            match_vec;
    logic [N-1:0]            rd_vec;
    logic [N-1:0]            wr_vec;
    logic [N-1:0]            used_vec;
    logic [N-1:0]            dirty_vec;
    logic [N-1:0][PFN_W-1:0] pfn_arr;
    logic [IW-1:0]           lfsr_q;
    logic [IW-1:0]           victim;
    logic                    fill_go;
    logic                    any_match;
    logic                    sel_rd;
    logic                    sel_wr;
    logic                    sel_used;
    logic                    sel_dirty;
    logic                    permit;
    logic [PFN_W-1:0]        sel_pfn;
    resp_t                   resp;

    assign fill_go = fill_valid && !flush_all && !flush_by_asid;

    tlb_lfsr #(.W(IW)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (fill_go),
        .q     (lfsr_q)
    );

    tlb_victim #(.N(N)) u_victim (
        .valid_vec (valid_vec),
        .rand_idx  (lfsr_q),
        .idx       (victim)
    );

    for (genvar g = 0; g < N; g++) begin : g_slot
        tlb_slot #(.VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W)) u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .clr_all     (flush_all),
            .clr_tag     (flush_by_asid),
            .clr_asid    (flush_asid),
            .load        (fill_go && (victim == IW'(g))),
            .ld_vpn      (fill_vpn),
            .ld_asid     (fill_asid),
            .ld_pfn      (fill_pfn),
            .ld_rd       (fill_rd),
            .ld_wr       (fill_wr),
            .probe       (lk_valid),
            .probe_write (lk_write),
            .probe_vpn   (lk_vpn),
            .probe_asid  (lk_asid),
            .valid       (valid_vec[g]),
            .match       (match_vec[g]),
            .pfn         (pfn_arr[g]),
            .rd_ok       (rd_vec[g]),
            .wr_ok       (wr_vec[g]),
            .used        (used_vec[g]),
            .dirty       (dirty_vec[g])
        );
    end

    always_comb begin
        sel_pfn   = '0;
        sel_rd    = 1'b0;
        sel_wr    = 1'b0;
        sel_used  = 1'b0;
        sel_dirty = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (match_vec[i]) begin
                sel_pfn   = sel_pfn | pfn_arr[i];
                sel_rd    = sel_rd | rd_vec[i];
                sel_wr    = sel_wr | wr_vec[i];
                sel_used  = sel_used | used_vec[i];
                sel_dirty = sel_dirty | dirty_vec[i];
            end
        end
    end

    assign any_match = |match_vec;
    assign permit    = lk_write ? sel_wr : sel_rd;

    always_comb begin
        if (!lk_valid) begin
            resp = RSP_NONE;
        end else if (!any_match) begin
            resp = RSP_MISS;
        end else if (permit) begin
            resp = RSP_HIT;
        end else begin
            resp = RSP_FAULT;
        end
    end

    always_comb begin
        lk_hit   = 1'b0;
        lk_miss  = 1'b0;
        lk_fault = 1'b0;
        lk_pfn   = '0;
        lk_used  = 1'b0;
        lk_dirty = 1'b0;
        unique case (resp)
            RSP_NONE: begin
            end
            RSP_MISS: begin
                lk_miss = 1'b1;
            end
            RSP_HIT: begin
                lk_hit   = 1'b1;
                lk_pfn   = sel_pfn;
                lk_used  = sel_used;
                lk_dirty = sel_dirty;
            end
            RSP_FAULT: begin
                lk_fault = 1'b1;
                lk_used  = sel_used;
                lk_dirty = sel_dirty;
            end
        endcase
    end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
    parameter int N      = 16,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int IW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic [VPN_W-1:0]  lk_vpn,
    input logic [ASID_W-1:0] lk_asid,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_fault,
    input logic              lk_used,
    input logic              fill_valid,
    input logic              flush_all,
    input logic              flush_by_asid,
    input logic [N-1:0]      match_vec,
    input logic [N-1:0]      valid_vec,
    input logic [IW-1:0]     lfsr_q
);
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> ($countones({lk_hit, lk_miss, lk_fault}) == 1)); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault)); // R4

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec)); // R12

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0)); // R9

    AST_USED_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && (lk_hit || lk_fault) && $past(lk_valid && (lk_hit || lk_fault)
         && !fill_valid && !flush_all && !flush_by_asid)
         && $stable(lk_vpn) && $stable(lk_asid)) |-> lk_used); // R5

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0); // R8
endmodule

bind tlb_fa tlb_fa_chk #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .IW(IW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_vpn        (lk_vpn),
    .lk_asid       (lk_asid),
    .lk_hit        (lk_hit),
    .lk_miss       (lk_miss),
    .lk_fault      (lk_fault),
    .lk_used       (lk_used),
    .fill_valid    (fill_valid),
    .flush_all     (flush_all),
    .flush_by_asid (flush_by_asid),
    .match_vec     (match_vec),
    .valid_vec     (valid_vec),
    .lfsr_q        (lfsr_q)
);

// File: tb/tlb_fa_test.sv
`timescale 1ns/1ps
module tlb_fa_test;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic [7:0]  lk_asid = '0;
    logic        lk_hit, lk_miss, lk_fault, lk_used, lk_dirty;
    logic [19:0] lk_pfn;
    logic        fill_valid = 1'b0, fill_rd = 1'b0, fill_wr = 1'b0;
    logic [19:0] fill_vpn = '0, fill_pfn = '0;
    logic [7:0]  fill_asid = '0;
    logic        flush_all = 1'b0, flush_by_asid = 1'b0;
    logic [7:0]  flush_asid = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model
    bit        m_valid [N];
    bit [19:0] m_vpn   [N];
    bit [7:0]  m_asid  [N];
    bit [19:0] m_pfn   [N];
    bit        m_rd    [N];
    bit        m_wr    [N];
    bit        m_used  [N];
    bit        m_dirty [N];
    bit [3:0]  m_lfsr;

    always #4 clk = ~clk;

    tlb_fa uut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault), .lk_pfn(lk_pfn),
        .lk_used(lk_used), .lk_dirty(lk_dirty),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_pfn(fill_pfn), .fill_rd(fill_rd), .fill_wr(fill_wr),
        .flush_all(flush_all), .flush_by_asid(flush_by_asid), .flush_asid(flush_asid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int m_find(input bit [19:0] v, input bit [7:0] a);
        for (int i = 0; i < N; i++)
            if (m_valid[i] && m_vpn[i] == v && m_asid[i] == a) return i;
        return -1;
    endfunction

    task automatic lookup(input string tag, input bit [19:0] v, input bit [7:0] a, input bit wr);
        int k;
        bit perm;
        logic [2:0] exp_r;
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v; lk_asid = a; lk_write = wr;
        #2;
        k = m_find(v, a);
        if (k < 0) exp_r = 3'b010;
        else begin
            perm = wr ? m_wr[k] : m_rd[k];
            exp_r = perm ? 3'b100 : 3'b001;
        end
        chk({tag, " result"}, {29'd0, lk_hit, lk_miss, lk_fault}, {29'd0, exp_r});
        if (exp_r == 3'b100) chk({tag, " pfn"}, {12'd0, lk_pfn}, {12'd0, m_pfn[k]});
        else chk({tag, " pfn zero"}, {12'd0, lk_pfn}, 32'd0);
        if (k >= 0) begin
            chk({tag, " used R5"}, {31'd0, lk_used}, {31'd0, m_used[k]});
            chk({tag, " dirty R6"}, {31'd0, lk_dirty}, {31'd0, m_dirty[k]});
        end
        @(posedge clk);
        #1;
        lk_valid = 1'b0;
        if (k >= 0) begin
            m_used[k] = 1'b1;
            if (wr && m_wr[k]) m_dirty[k] = 1'b1;
        end
    endtask

    task automatic fill(input bit [19:0] v, input bit [7:0] a, input bit [19:0] p,
                        input bit r, input bit w, input bit fl_all, input bit fl_tag,
                        input bit [7:0] fa);
        int vi;
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p;
        fill_rd = r; fill_wr = w;
        flush_all = fl_all; flush_by_asid = fl_tag; flush_asid = fa;
        @(posedge clk);
        #1;
        fill_valid = 1'b0; flush_all = 1'b0; flush_by_asid = 1'b0;
        if (fl_all) begin
            for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        end else if (fl_tag) begin
            for (int i = 0; i < N; i++) if (m_asid[i] == fa) m_valid[i] = 1'b0;
        end else begin
            vi = m_lfsr;
            for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) vi = i;
            m_valid[vi] = 1'b1; m_vpn[vi] = v; m_asid[vi] = a; m_pfn[vi] = p;
            m_rd[vi] = r; m_wr[vi] = w; m_used[vi] = 1'b0; m_dirty[vi] = 1'b0;
            m_lfsr = {m_lfsr[2:0], m_lfsr[3] ^ m_lfsr[2]};
        end
    endtask

    task automatic flush(input bit fl_all, input bit [7:0] fa);
        @(negedge clk);
        flush_all = fl_all; flush_by_asid = !fl_all; flush_asid = fa;
        @(posedge clk);
        #1;
        flush_all = 1'b0; flush_by_asid = 1'b0;
        for (int i = 0; i < N; i++)
            if (fl_all || m_asid[i] == fa) m_valid[i] = 1'b0;
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < N; i++)
            if (m_valid[i]) lookup(tag, m_vpn[i], m_asid[i], 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_used[i] = 0; m_dirty[i] = 0;
        end
        m_lfsr = 4'b0001;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        for (int i = 0; i < N; i++) lookup("R1 reset miss", 20'h100 + 20'(i), 8'(i % 3), 1'b0);

        // R7: fill all slots from empty
        for (int i = 0; i < N; i++)
            fill(20'h100 + 20'(i), 8'(i % 3), 20'h5000 + 20'(i * 7), (i % 4) != 3, (i % 2) == 0,
                 1'b0, 1'b0, 8'h0);

        // R2 R4: reads and writes, permitted and faulting
        for (int i = 0; i < N; i++) begin
            lookup("R2 R4 read", 20'h100 + 20'(i), 8'(i % 3), 1'b0);
            lookup("R4 R6 write", 20'h100 + 20'(i), 8'(i % 3), 1'b1);
            lookup("R5 R6 reread", 20'h100 + 20'(i), 8'(i % 3), 1'b0);
            lookup("R3 wrong tag", 20'h100 + 20'(i), 8'(i % 3 + 3), 1'b0);
        end

        // R8: random replacement when full
        for (int j = 0; j < 6; j++) begin
            fill(20'h200 + 20'(j), 8'h7, 20'h9000 + 20'(j), 1'b1, 1'b1, 1'b0, 1'b0, 8'h0);
            lookup("R8 new entry", 20'h200 + 20'(j), 8'h7, 1'b0);
        end
        for (int i = 0; i < N; i++) lookup("R8 old survivors", 20'h100 + 20'(i), 8'(i % 3), 1'b0);
        for (int j = 0; j < 6; j++) lookup("R8 new survivors", 20'h200 + 20'(j), 8'h7, 1'b0);

        // R10: selective flush
        flush(1'b0, 8'h1);
        for (int i = 0; i < N; i++) lookup("R10 tag flush", 20'h100 + 20'(i), 8'(i % 3), 1'b0);
        sweep("R10 others kept");

        // R7: refill into holes displaces nothing
        for (int j = 0; j < 3; j++)
            fill(20'h300 + 20'(j), 8'h9, 20'hA000 + 20'(j), 1'b1, 1'b0, 1'b0, 1'b0, 8'h0);
        sweep("R7 holes first");

        // R11: fill dropped when a flush coincides
        fill(20'h400, 8'h4, 20'hBBBB, 1'b1, 1'b1, 1'b0, 1'b1, 8'h55);
        lookup("R11 dropped tag", 20'h400, 8'h4, 1'b0);
        fill(20'h401, 8'h4, 20'hBBBC, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0);
        sweep("R11 lfsr unchanged");

        // R9: flush all
        flush(1'b1, 8'h0);
        for (int i = 0; i < N; i++) lookup("R9 flush all", 20'h100 + 20'(i), 8'(i % 3), 1'b0);
        lookup("R9 flush all new", 20'h401, 8'h4, 1'b0);
        fill(20'h402, 8'h4, 20'hCCCC, 1'b1, 1'b1, 1'b1, 1'b0, 8'h0);
        lookup("R11 dropped all", 20'h402, 8'h4, 1'b0);

        // R3 R12: same page under two tags, exactly one answer each
        fill(20'h777, 8'h5, 20'h11111, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0);
        fill(20'h777, 8'h6, 20'h22222, 1'b1, 1'b1, 1'b0, 1'b0, 8'h0);
        lookup("R3 R12 tag5", 20'h777, 8'h5, 1'b0);
        lookup("R3 R12 tag6", 20'h777, 8'h6, 1'b1);
        lookup("R3 tag7 miss", 20'h777, 8'h7, 1'b0);

        // R4: idle outputs quiet
        @(negedge clk);
        #2;
        chk("R4 idle", {29'd0, lk_hit, lk_miss, lk_fault}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule